// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

This block drives one DMA channel from a chain of descriptors held in memory. Software or a sequencer pulses a start input together with the address of the first descriptor. The walker then reads the eight-byte record at that address one byte at a time. It checks the record, and for an accepted entry it presents the buffer address and byte count to a data mover. It keeps that request up until the mover reports the transfer finished. It then steps eight bytes forward to the next record, and the chain ends at the record that carries the end-of-chain flag.

Each record is little-endian. Byte 0 holds the flags, byte 1 is unused, bytes 2 and 3 hold the byte count, and bytes 4 to 7 hold the buffer address. A record that is not marked usable, or whose count is not a whole number of 32-bit words, ends the walk early with an error indication. The walker moves no data itself, and it takes part in no bus arbitration.

Top module: `sgw_walker`

## Requirements
- R1: After synchronous reset, `busy`, `rd_req`, `xfer_req`, `walk_done` and `walk_err` are all 0.
- R2: A start accepted in idle takes `list_addr` as the first record address. The record's bytes are read at ascending addresses base+0 to base+7. A byte is taken on a cycle with `rd_req` and `rd_valid` both high, and `rd_addr` is held while a request waits. Each following record is read at the previous base plus 8.
- R3: For an accepted record, `xfer_addr` is bytes 4..7 and `xfer_len` is bytes 2..3, both least significant byte first. `xfer_req` stays high with both values stable until the cycle in which `xfer_done` is high.
- R4: A record is usable when flag bits 0 and 5 are both set (value 0x21). Flag bit 1 (value 0x23 overall) marks the last record, and records without it lead to a fetch of the next record after the transfer.
- R5: On the clock edge where `xfer_done` completes the last record, the walker goes idle. `walk_done` is then high for exactly one cycle, with `busy` already low.
- R6: A record lacking flag bit 0 or bit 5 issues no transfer. It sets `walk_err`, pulses `walk_done` and returns to idle.
- R7: A record whose count has either of bits 1..0 set issues no transfer. It sets `walk_err`, pulses `walk_done` and returns to idle.
- R8: A start pulse while `busy` is high is ignored: the addresses read and the transfers issued are unchanged.
- R9: `walk_err` stays set after an error walk until the next accepted start, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (taken only in idle) |
| list_addr | input | 32 | Address of the first record |
| rd_req | output | 1 | Record byte read request |
| rd_addr | output | 32 | Byte address being read |
| rd_valid | input | 1 | Read data present this cycle |
| rd_data | input | 8 | Read data byte |
| xfer_req | output | 1 | Transfer request to the data mover |
| xfer_addr | output | 32 | Buffer address of the transfer |
| xfer_len | output | 16 | Byte count of the transfer |
| xfer_done | input | 1 | Data mover finished the transfer |
| walk_done | output | 1 | One-cycle end-of-walk pulse |
| walk_err | output | 1 | Walk ended on a rejected record |
| busy | output | 1 | A walk is in progress |

## Verification
The bench uses random read stalls and random transfer latency. These catch a walker that advances its byte index or drops its request without an accepted read, since that would show up as a wrong read address or a scrambled buffer address. Lists of three records, one record, and records carrying the largest word-aligned count with all address bytes distinct would expose swapped byte lanes, a missing 8-byte stride, or an early stop before the flagged last record. Rejected records are tried both with the usable bit missing and with a count that is a multiple of two but not of four. A design that still issued them would raise a transfer request and show a transfer count one too high. A start pulse in mid-walk and a clean walk after an error show whether the chain base gets clobbered or a stale error flag survives.

// File: rtl/sgw_pkg.sv
package sgw_pkg;

    localparam int unsigned ADDR_W    = 32;
    localparam int unsigned LEN_W     = 16;
    localparam int unsigned REC_BYTES = 8;
    localparam int unsigned IDX_W     = $clog2(REC_BYTES);
    localparam int unsigned LEN_LO    = 2;             // first count byte
    localparam int unsigned ADDR_LO   = LEN_LO + LEN_W / 8;  // first address byte

    // flag bit positions inside record byte 0
    localparam int unsigned FB_USE  = 0;
    localparam int unsigned FB_LAST = 1;
    localparam int unsigned FB_MOVE = 5;

    typedef enum logic [1:0] {
        W_IDLE,
        W_FETCH,
        W_ISSUE
    } walk_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] buf_addr;
        logic [LEN_W-1:0]  len;
        logic              fl_move;
        logic              fl_last;
        logic              fl_use;
    } rec_t;

    typedef struct packed {
        logic ok;
        logic last;
    } verdict_t;

    function automatic verdict_t judge(input rec_t r);
        verdict_t v;
        v.ok   = r.fl_use && r.fl_move && (r.len[1:0] == 2'b00);
        v.last = r.fl_last;
        return v;
    endfunction

endpackage

// File: rtl/sgw_fetch.sv
module sgw_fetch
    import sgw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [ADDR_W-1:0] base,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [7:0]        rd_data,
    output logic              rec_vld,
    output rec_t              rec
);

    logic [IDX_W-1:0] idx;
    logic             take;
    logic [2:0]       flag_q;
    logic [7:0]       lane [LEN_LO:REC_BYTES-1];

    assign rd_req  = en && !rec_vld;
    assign rd_addr = base + ADDR_W'(idx);
    assign take    = rd_req && rd_valid;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            idx     <= '0;
            rec_vld <= 1'b0;
        end else begin
            rec_vld <= 1'b0;
            if (take) begin
                if (idx == IDX_W'(REC_BYTES - 1)) begin
                    idx     <= '0;
                    rec_vld <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
        end else if (take && idx == '0) begin
            flag_q <= {rd_data[FB_MOVE], rd_data[FB_LAST], rd_data[FB_USE]};
        end
    end

    for (genvar g = LEN_LO; g < REC_BYTES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                lane[g] <= '0;
            end else if (take && idx == IDX_W'(g)) begin
                lane[g] <= rd_data;
            end
        end
    end

    always_comb begin
        rec.fl_use  = flag_q[0];
        rec.fl_last = flag_q[1];
        rec.fl_move = flag_q[2];
        for (int b = 0; b < LEN_W / 8; b++) begin
            rec.len[b*8 +: 8] = lane[LEN_LO + b];
        end
        for (int b = 0; b < ADDR_W / 8; b++) begin
            rec.buf_addr[b*8 +: 8] = lane[ADDR_LO + b];
        end
    end

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

    // R2
    rec_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rec_vld |=> !rec_vld);

endmodule

// File: rtl/sgw_ctrl.sv
module sgw_ctrl
    import sgw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] list_addr,
    input  logic              rec_vld,
    input  rec_t              rec,
    input  logic              xfer_done,
    output logic              fetch_en,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              xfer_req,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic [LEN_W-1:0]  xfer_len,
    output logic              walk_done,
    output logic              walk_err,
    output logic              busy
);

    walk_state_e st;
    logic        last_q;
    verdict_t    v;

    assign v        = judge(rec);
    assign fetch_en = (st == W_FETCH);
    assign xfer_req = (st == W_ISSUE);
    assign busy     = (st != W_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= W_IDLE;
            cur_addr  <= '0;
            xfer_addr <= '0;
            xfer_len  <= '0;
            last_q    <= 1'b0;
            walk_done <= 1'b0;
            walk_err  <= 1'b0;
        end else begin
            walk_done <= 1'b0;
            unique case (st)
                W_IDLE: begin
                    if (start) begin
                        cur_addr <= list_addr;
                        walk_err <= 1'b0;
                        st       <= W_FETCH;
                    end
                end
                W_FETCH: begin
                    if (rec_vld) begin
                        if (v.ok) begin
                            xfer_addr <= rec.buf_addr;
                            xfer_len  <= rec.len;
                            last_q    <= v.last;
                            st        <= W_ISSUE;
                        end else begin
                            walk_err  <= 1'b1;
                            walk_done <= 1'b1;
                            st        <= W_IDLE;
                        end
                    end
                end
                W_ISSUE: begin
                    if (xfer_done) begin
                        if (last_q) begin
                            walk_done <= 1'b1;
                            st        <= W_IDLE;
                        end else begin
                            cur_addr <= cur_addr + ADDR_W'(REC_BYTES);
                            st       <= W_FETCH;
                        end
                    end
                end
                default: st <= W_IDLE;
            endcase
        end
    end

    // R3
    xfer_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_req && !xfer_done) |=>
            (xfer_req && $stable(xfer_addr) && $stable(xfer_len)));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        walk_done |=> !walk_done);

    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        walk_done |-> !busy);

    // R6
    no_err_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_req |-> !walk_err);

    // R7
    aligned_len_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_req |-> (xfer_len[1:0] == 2'b00));

endmodule

// File: rtl/sgw_walker.sv
module sgw_walker
    import sgw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] list_addr,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [7:0]        rd_data,
    output logic              xfer_req,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic [LEN_W-1:0]  xfer_len,
    input  logic              xfer_done,
    output logic              walk_done,
    output logic              walk_err,
    output logic              busy
);

    logic              fetch_en;
    logic [ADDR_W-1:0] cur_addr;
    logic              rec_vld;
    rec_t              rec;

    sgw_fetch u_fetch (
        .clk      (clk),
        .rst      (rst),
        .en       (fetch_en),
        .base     (cur_addr),
        .rd_req   (rd_req),
        .rd_addr  (rd_addr),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .rec_vld  (rec_vld),
        .rec      (rec)
    );

    sgw_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .list_addr (list_addr),
        .rec_vld   (rec_vld),
        .rec       (rec),
        .xfer_done (xfer_done),
        .fetch_en  (fetch_en),
        .cur_addr  (cur_addr),
        .xfer_req  (xfer_req),
        .xfer_addr (xfer_addr),
        .xfer_len  (xfer_len),
        .walk_done (walk_done),
        .walk_err  (walk_err),
        .busy      (busy)
    );

    // R8
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !walk_done && start && !xfer_req && !rd_req) |=> busy);

endmodule

// File: tb/sgw_walker_test.sv
`timescale 1ns/1ps
module sgw_walker_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] list_addr = '0;
    logic        rd_req;
    logic [31:0] rd_addr;
    logic        rd_valid = 1'b0;
    logic [7:0]  rd_data;
    logic        xfer_req;
    logic [31:0] xfer_addr;
    logic [15:0] xfer_len;
    logic        xfer_done = 1'b0;
    logic        walk_done;
    logic        walk_err;
    logic        busy;

    logic [7:0]  mem [0:255];
    int          checks = 0;
    int          errors = 0;
    int          nxfer  = 0;
    int          cycles = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    assign rd_data = mem[rd_addr[7:0]];

    sgw_walker uut (
        .clk(clk), .rst(rst), .start(start), .list_addr(list_addr),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .xfer_req(xfer_req), .xfer_addr(xfer_addr), .xfer_len(xfer_len),
        .xfer_done(xfer_done), .walk_done(walk_done), .walk_err(walk_err),
        .busy(busy)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int          mph;
    logic [31:0] mcur;
    int          midx;
    bit          mrecv, mdone, merr, mlast;
    logic [7:0]  mb [8];
    logic [31:0] mxa;
    logic [15:0] mxl;

    always @(posedge clk) begin
        if (rst) begin
            mph = 0; mcur = 0; midx = 0; mrecv = 0; mdone = 0; merr = 0;
            mlast = 0; mxa = 0; mxl = 0;
        end else begin
            mdone = 0;
            case (mph)
                0: if (start) begin
                    mcur = list_addr; merr = 0; mph = 1; midx = 0; mrecv = 0;
                end
                1: if (mrecv) begin
                    logic [7:0]  f;
                    logic [15:0] l;
                    mrecv = 0;
                    f = mb[0];
                    l = {mb[3], mb[2]};
                    if (!(f[0] && f[5]) || l[1:0] != 2'b00) begin
                        merr = 1; mdone = 1; mph = 0;
                    end else begin
                        mxa = {mb[7], mb[6], mb[5], mb[4]};
                        mxl = l; mlast = f[1]; mph = 2;
                    end
                end else if (rd_valid) begin
                    mb[midx] = mem[8'(mcur + 32'(midx))];
                    if (midx == 7) begin midx = 0; mrecv = 1; end
                    else midx++;
                end
                2: if (xfer_done) begin
                    if (mlast) begin mdone = 1; mph = 0; end
                    else begin mcur = mcur + 8; mph = 1; end
                end
                default: mph = 0;
            endcase
        end
    end

    // cycle-by-cycle comparison
    always @(negedge clk) begin
        if (!rst) begin
            chk("R8", "busy", {31'b0, busy}, {31'b0, mph != 0});
            chk("R2", "rd_req", {31'b0, rd_req}, {31'b0, (mph == 1) && !mrecv});
            if (mph == 1 && !mrecv) chk("R2", "rd_addr", rd_addr, mcur + 32'(midx));
            chk("R3", "xfer_req", {31'b0, xfer_req}, {31'b0, mph == 2});
            if (mph == 2) begin
                chk("R3", "xfer_addr", xfer_addr, mxa);
                chk("R3", "xfer_len", {16'b0, xfer_len}, {16'b0, mxl});
            end
            chk("R5", "walk_done", {31'b0, walk_done}, {31'b0, mdone});
            chk("R9", "walk_err", {31'b0, walk_err}, {31'b0, merr});
        end
    end

    // memory stalls and data mover latency
    always @(negedge clk) begin
        lfsr      <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        rd_valid  <= lfsr[0] | lfsr[3];
        xfer_done <= xfer_req && lfsr[2] && lfsr[7];
        if (xfer_req && lfsr[2] && lfsr[7]) nxfer <= nxfer + 1;
    end

    // watchdog
    always @(negedge clk) begin
        cycles++;
        if (cycles >= 100000) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic put_rec(input int base, input logic [7:0] fl,
                           input logic [15:0] len, input logic [31:0] a);
        mem[base]   = fl;
        mem[base+1] = 8'h5A;
        mem[base+2] = len[7:0];
        mem[base+3] = len[15:8];
        mem[base+4] = a[7:0];
        mem[base+5] = a[15:8];
        mem[base+6] = a[23:16];
        mem[base+7] = a[31:24];
    endtask

    task automatic walk(input logic [31:0] a, input bit exp_err,
                        input int exp_n, input string tag, input bit poke);
        int n0;
        n0 = nxfer;
        @(negedge clk);
        start <= 1'b1; list_addr <= a;
        @(negedge clk);
        start <= 1'b0;
        if (poke) begin
            repeat (5) @(negedge clk);
            start <= 1'b1; list_addr <= 32'h0000_0080;   // R8: must be ignored
            @(negedge clk);
            start <= 1'b0;
        end
        while (!walk_done) @(negedge clk);
        chk(tag, "walk_err at end", {31'b0, walk_err}, {31'b0, exp_err});
        chk(tag, "transfer count", 32'(nxfer - n0), 32'(exp_n));
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        // three-record chain
        put_rec(8'h10, 8'h21, 16'h0100, 32'h1234_5678);
        put_rec(8'h18, 8'h21, 16'h0004, 32'hA0B0_C0D0);
        put_rec(8'h20, 8'h23, 16'hFFFC, 32'hDEAD_BEEF);
        // second record lacks the move bit
        put_rec(8'h40, 8'h21, 16'h0010, 32'h0000_1000);
        put_rec(8'h48, 8'h01, 16'h0010, 32'h0000_2000);
        // misaligned count
        put_rec(8'h60, 8'h23, 16'h0006, 32'h0000_3000);
        // single record
        put_rec(8'h80, 8'h23, 16'h0040, 32'h0000_0400);
        // usable bit missing
        put_rec(8'hA0, 8'h20, 16'h0008, 32'h0000_5000);

        repeat (4) @(negedge clk);
        rst <= 1'b0;
        @(negedge clk);
        // R1
        chk("R1", "busy after reset", {31'b0, busy}, 32'd0);
        chk("R1", "rd_req after reset", {31'b0, rd_req}, 32'd0);
        chk("R1", "xfer_req after reset", {31'b0, xfer_req}, 32'd0);
        chk("R1", "walk_done after reset", {31'b0, walk_done}, 32'd0);
        chk("R1", "walk_err after reset", {31'b0, walk_err}, 32'd0);

        walk(32'h10, 1'b0, 3, "R4", 1'b0);
        walk(32'h80, 1'b0, 1, "R5", 1'b0);
        walk(32'h40, 1'b1, 1, "R6", 1'b0);
        walk(32'h80, 1'b0, 1, "R9", 1'b0);
        walk(32'h60, 1'b1, 0, "R7", 1'b0);
        walk(32'hA0, 1'b1, 0, "R6", 1'b0);
        walk(32'h10, 1'b0, 3, "R8", 1'b1);
        walk(32'h80, 1'b0, 1, "R2", 1'b0);

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule